// File: doc/BRIEF.md
# SECDED-Protected Word Memory

This block is a single-clock synchronous memory of 64-bit words. Each word is stored beside an 8-bit check field of a single-error-correct, double-error-detect Hamming code. Two static parameters switch the write-side encoder and the read-side decoder on or off independently. That gives four configurations: full protection, encode-only, decode-only and unprotected storage.

When the encoder is off, the check field is taken from an external input. With the decoder on, a test can then store a word whose data and check bits deliberately disagree, which exercises the correction logic.

The read port returns the word, its check field (corrected when the decoder repairs it) and two error flags. A parameter selects a one-stage or two-stage read pipeline. The flags always leave the block in the same cycle as the word they describe.

Top module: `secded_ram`

## Requirements
- R1: With both encoder and decoder enabled, a word written and later read back returns the same 64 data bits. Its check field equals the code check bits of that data, and both flags are low.
- R2: The code is defined as follows. Data bit i occupies the i-th codeword position, counting upward from 1 through 71 and skipping powers of two. Check bit b (b = 0..6) is the XOR of the data bits whose position has bit b set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. With the encoder enabled, `wr_chk_out` shows the check bits of the write data from the cycle after a write, and holds until the next write. With the encoder disabled, it stays zero.
- R3: With READ_STAGES=1, read results appear one clock after the cycle that presents `rd_en`. With READ_STAGES=2 they appear two clocks after. The flags are aligned with the data in both cases.
- R4: With the encoder disabled, the stored check field is the value on `wr_chk` at the write.
- R5: With the decoder enabled, a word holding exactly one flipped data bit is returned with that bit restored. `rd_chk` equals the code check bits, `rd_sbe` is 1 and `rd_dbe` is 0.
- R6: With the decoder enabled, a single flipped check bit (including bit 7) is restored, and `rd_sbe` is 1.
- R7: With the decoder enabled, two flipped bits are flagged by `rd_dbe`=1 and `rd_sbe`=0. This holds for two data bits, two check bits, or one of each. The stored data and check field are returned unmodified.
- R8: `rd_sbe` and `rd_dbe` are never high together.
- R9: With the decoder disabled, a read returns the stored data and check field unchanged, and neither flag is ever raised.
- R10: With both encoder and decoder disabled, `wr_chk` is stored and returned unchanged, and both flags stay low.
- R11: While `rst_n` is low at a clock edge, `rd_data`, `rd_chk`, `rd_sbe`, `rd_dbe` and `wr_chk_out` become zero.
- R12: The read outputs keep their value until a new read reaches the output stage, even when the memory is written in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 64 | Write data |
| wr_chk | input | 8 | External check field, stored when the encoder is disabled |
| wr_chk_out | output | 8 | Check bits computed for the last write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 64 | Read data, corrected when the decoder is enabled |
| rd_chk | output | 8 | Read check field, corrected when the decoder is enabled |
| rd_sbe | output | 1 | Single error corrected |
| rd_dbe | output | 1 | Double error detected |

## Verification
The assertions check several properties on every cycle. The two flags stay exclusive. A single-error correction changes exactly one codeword bit, and a flagged double error or a clean word passes through untouched. The read outputs and `wr_chk_out` stay put without a new read or write, and the flags stay low whenever the decoder is disabled. Other behaviours can only be shown by the bench's scenarios: which bit is repaired, the exact check value for a given word, the read latency of each pipeline depth, and the storage of an external check field. For these the bench runs four configurations side by side and injects single and double faults through the external check input and through altered data.

// File: rtl/secded_pkg.sv
// Shared constants and constant functions for the (72,64) SECDED code.
// Assumes data bits fill codeword positions 1..71 that are not powers of two,
// in ascending order; check bits 0..6 cover by position bit, bit 7 is overall parity.
package secded_pkg;
    localparam int DATA_W   = 64;
    localparam int HAM_W    = 7;
    localparam int CHK_W    = 8;
    localparam int CODE_LEN = 71;

    // Codeword position of data bit idx.
    function automatic logic [HAM_W-1:0] data_pos(input int idx);
        logic [HAM_W-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int p = 1; p <= CODE_LEN; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (k == idx) r = p[HAM_W-1:0];
                k++;
            end
        end
        return r;
    endfunction

    // Mask of the data bits that check bit bitn covers.
    function automatic logic [DATA_W-1:0] cover_mask(input int bitn);
        logic [DATA_W-1:0] m;
        logic [HAM_W-1:0]  p;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            p    = data_pos(i);
            m[i] = p[bitn[2:0]];
        end
        return m;
    endfunction
endpackage

// File: rtl/secded_enc.sv
// Combinational check-bit generator: seven position-coverage parities plus
// one overall parity over data and those seven bits. Assumes nothing about timing.
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    logic [HAM_W-1:0] ham;

    // One reduction XOR per coverage check bit.
    for (genvar b = 0; b < HAM_W; b++) begin : g_cover
        localparam logic [DATA_W-1:0] MASK = cover_mask(b);
        assign ham[b] = ^(data & MASK);
    end

    // Overall parity closes the codeword to even weight.
    assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/secded_dec.sv
// Combinational SECDED corrector. Recomputes the check bits, forms the syndrome
// and overall parity, repairs one flipped bit anywhere in the 72-bit word and
// flags two. Clock and reset are used only by the embedded checks.
module secded_dec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw_data,
    input  logic [CHK_W-1:0]  raw_chk,
    output logic [DATA_W-1:0] fix_data,
    output logic [CHK_W-1:0]  fix_chk,
    output logic              sbe,
    output logic              dbe
);
    logic [CHK_W-1:0]  fresh;
    logic [HAM_W-1:0]  syn;
    logic              odd;
    logic              in_range;
    logic              single;
    logic [DATA_W-1:0] dflip;
    logic [CHK_W-1:0]  cflip;

    secded_enc u_recalc (.data(raw_data), .chk(fresh));

    // Syndrome and received-word parity (odd means an odd number of flips).
    assign syn      = fresh[HAM_W-1:0] ^ raw_chk[HAM_W-1:0];
    assign odd      = fresh[CHK_W-1] ^ raw_chk[CHK_W-1] ^ (^syn);
    assign in_range = (int'(syn) <= CODE_LEN);

    // Classify: odd parity with a valid position is correctable.
    always_comb begin
        single = odd && in_range;
        dbe    = (odd && !in_range) || (!odd && (syn != '0));
    end
    assign sbe = single;

    // Data flip mask: one comparator per data bit against its position.
    for (genvar i = 0; i < DATA_W; i++) begin : g_dflip
        localparam logic [HAM_W-1:0] POS = data_pos(i);
        assign dflip[i] = single && (syn == POS);
    end

    // Check flip mask: powers of two select check bits, zero selects overall parity.
    for (genvar b = 0; b < HAM_W; b++) begin : g_cflip
        localparam logic [HAM_W-1:0] HOT = HAM_W'(1 << b);
        assign cflip[b] = single && (syn == HOT);
    end
    assign cflip[CHK_W-1] = single && (syn == '0);

    assign fix_data = raw_data ^ dflip;
    assign fix_chk  = raw_chk ^ cflip;

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sbe && dbe));
    assert_single_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sbe |-> ($countones({fix_data, fix_chk} ^ {raw_data, raw_chk}) == 1));
    assert_double_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbe |-> ({fix_data, fix_chk} == {raw_data, raw_chk}));
    assert_clean_untouched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sbe && !dbe) |-> ({fix_data, fix_chk} == {raw_data, raw_chk}));
endmodule

// File: rtl/secded_array.sv
// Word storage with one write port and one registered read port.
// Assumes no read and write to the same address in one cycle; the read
// register holds between reads and clears on synchronous reset.
module secded_array #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int WORD_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;

    // Store a word on a write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
    end

    // Capture the addressed word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr];
    end

    assign rd_word = rd_q;

    assert_wr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));
    assert_rd_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < DEPTH));
endmodule

// File: rtl/secded_ram.sv
// SECDED-protected memory top. ENC_ON selects computed versus external check
// bits at write; DEC_ON selects corrected versus raw read; READ_STAGES (1 or 2)
// sets read latency, with flags travelling in the same stage as the word.
module secded_ram
    import secded_pkg::*;
#(
    parameter int DEPTH       = 512,
    parameter int ADDR_W      = $clog2(DEPTH),
    parameter bit ENC_ON      = 1'b1,
    parameter bit DEC_ON      = 1'b1,
    parameter int READ_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CHK_W-1:0]  wr_chk,
    output logic [CHK_W-1:0]  wr_chk_out,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CHK_W-1:0]  rd_chk,
    output logic              rd_sbe,
    output logic              rd_dbe
);
    localparam int WORD_W = DATA_W + CHK_W;

    logic [CHK_W-1:0]  enc_chk;
    logic [CHK_W-1:0]  store_chk;
    logic [CHK_W-1:0]  chk_out_q;
    logic [WORD_W-1:0] arr_word;
    logic [DATA_W-1:0] fix_data;
    logic [CHK_W-1:0]  fix_chk;
    logic              fix_sbe;
    logic              fix_dbe;
    logic [DATA_W-1:0] s1_data;
    logic [CHK_W-1:0]  s1_chk;
    logic              s1_sbe;
    logic              s1_dbe;

    secded_enc u_wenc (.data(wr_data), .chk(enc_chk));

    // Choose computed or externally supplied check bits for storage.
    assign store_chk = ENC_ON ? enc_chk : wr_chk;

    // Report the computed check bits of each write, zero when encoding is off.
    always_ff @(posedge clk) begin
        if (!rst_n)     chk_out_q <= '0;
        else if (wr_en) chk_out_q <= ENC_ON ? enc_chk : '0;
    end
    assign wr_chk_out = chk_out_q;

    secded_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_word({store_chk, wr_data}),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_word(arr_word)
    );

    secded_dec u_rdec (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_data(arr_word[DATA_W-1:0]),
        .raw_chk (arr_word[WORD_W-1:DATA_W]),
        .fix_data(fix_data),
        .fix_chk (fix_chk),
        .sbe     (fix_sbe),
        .dbe     (fix_dbe)
    );

    // Pick corrected or raw word and gate flags by decoder enable.
    always_comb begin
        s1_data = DEC_ON ? fix_data : arr_word[DATA_W-1:0];
        s1_chk  = DEC_ON ? fix_chk  : arr_word[WORD_W-1:DATA_W];
        s1_sbe  = DEC_ON && fix_sbe;
        s1_dbe  = DEC_ON && fix_dbe;
    end

    if (READ_STAGES == 2) begin : g_two_stage
        logic              s1_vld;
        logic [DATA_W-1:0] q_data;
        logic [CHK_W-1:0]  q_chk;
        logic              q_sbe;
        logic              q_dbe;

        // Track which cycles carry a freshly read word in stage one.
        always_ff @(posedge clk) begin
            if (!rst_n) s1_vld <= 1'b0;
            else        s1_vld <= rd_en;
        end

        // Second output register, loaded only with a fresh word and its flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_data <= '0;
                q_chk  <= '0;
                q_sbe  <= 1'b0;
                q_dbe  <= 1'b0;
            end else if (s1_vld) begin
                q_data <= s1_data;
                q_chk  <= s1_chk;
                q_sbe  <= s1_sbe;
                q_dbe  <= s1_dbe;
            end
        end

        assign rd_data = q_data;
        assign rd_chk  = q_chk;
        assign rd_sbe  = q_sbe;
        assign rd_dbe  = q_dbe;

        assert_hold_two_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rd_en, 2) |-> $stable({rd_data, rd_chk, rd_sbe, rd_dbe}));
    end else begin : g_one_stage
        assign rd_data = s1_data;
        assign rd_chk  = s1_chk;
        assign rd_sbe  = s1_sbe;
        assign rd_dbe  = s1_dbe;

        assert_hold_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rd_en) |-> $stable({rd_data, rd_chk, rd_sbe, rd_dbe}));
    end

    if (!DEC_ON) begin : g_quiet
        assert_flags_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_sbe || rd_dbe));
    end

    if (!ENC_ON) begin : g_noenc_chk
        assert_chk_out_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_chk_out == '0);
    end

    assert_chk_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(wr_chk_out));
    assert_out_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_sbe && rd_dbe));
endmodule

// File: tb/secded_ram_test.sv
// Scoreboard bench: four configurations share one input stream; the read task
// queues expected results with their due cycle, a monitor compares them.
module secded_ram_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [7:0] wr_chk = '0;
    logic       rd_en = 1'b0;
    logic [8:0] rd_addr = '0;

    logic [7:0]  f_co, d_co, e_co, r_co;
    logic [63:0] f_d, d_d, e_d, r_d;
    logic [7:0]  f_c, d_c, e_c, r_c;
    logic        f_s, d_s, e_s, r_s, f_e, d_e, e_e, r_e;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [63:0] d;
        logic [7:0]  c;
        logic        s;
        logic        e;
        int          due;
        int          req;
    } exp_t;

    exp_t q_full[$], q_dec[$], q_enc[$], q_raw[$];

    logic [63:0] m_store [16];
    logic [7:0]  m_ext   [16];
    logic [63:0] m_dd    [16];
    logic [7:0]  m_dc    [16];
    logic        m_ds    [16];
    logic        m_de    [16];
    int          m_req   [16];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    secded_ram #(.ENC_ON(1'b1), .DEC_ON(1'b1), .READ_STAGES(1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_chk(wr_chk), .wr_chk_out(f_co), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(f_d), .rd_chk(f_c), .rd_sbe(f_s), .rd_dbe(f_e));
    secded_ram #(.ENC_ON(1'b0), .DEC_ON(1'b1), .READ_STAGES(2)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_chk(wr_chk), .wr_chk_out(d_co), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(d_d), .rd_chk(d_c), .rd_sbe(d_s), .rd_dbe(d_e));
    secded_ram #(.ENC_ON(1'b1), .DEC_ON(1'b0), .READ_STAGES(1)) u_enc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_chk(wr_chk), .wr_chk_out(e_co), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(e_d), .rd_chk(e_c), .rd_sbe(e_s), .rd_dbe(e_e));
    secded_ram #(.ENC_ON(1'b0), .DEC_ON(1'b0), .READ_STAGES(2)) u_raw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_chk(wr_chk), .wr_chk_out(r_co), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(r_d), .rd_chk(r_c), .rd_sbe(r_s), .rd_dbe(r_e));

    // Reference check bits from the code definition in R2.
    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [6:0] h;
        int p;
        h = '0;
        p = 2;
        for (int i = 0; i < 64; i++) begin
            p++;
            while ((p & (p - 1)) == 0) p++;
            for (int b = 0; b < 7; b++) if (p[b]) h[b] = h[b] ^ d[i];
        end
        return {(^d) ^ (^h), h};
    endfunction

    task automatic check(input string what, input logic [73:0] act, input logic [73:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cmp(input string who, input exp_t e, input logic [63:0] ad,
                       input logic [7:0] ac, input logic as, input logic ae);
        n_chk++;
        if ({ad, ac, as, ae} !== {e.d, e.c, e.s, e.e}) begin
            n_fail++;
            $display("FAIL %s R%0d (R3 read timing) actual d=%h c=%h s=%b e=%b expected d=%h c=%h s=%b e=%b",
                     who, e.req, ad, ac, as, ae, e.d, e.c, e.s, e.e);
        end
        n_chk++;
        if (as && ae) begin
            n_fail++;
            $display("FAIL %s R8 both flags: actual 11 expected not both", who);
        end
    endtask

    // Monitor: pop each expected item in its due cycle and compare.
    always @(negedge clk) begin
        exp_t e;
        if (q_full.size() > 0 && q_full[0].due == cyc) begin e = q_full.pop_front(); cmp("full", e, f_d, f_c, f_s, f_e); end
        if (q_dec.size()  > 0 && q_dec[0].due  == cyc) begin e = q_dec.pop_front();  cmp("dec",  e, d_d, d_c, d_s, d_e); end
        if (q_enc.size()  > 0 && q_enc[0].due  == cyc) begin e = q_enc.pop_front();  cmp("enc",  e, e_d, e_c, e_s, e_e); end
        if (q_raw.size()  > 0 && q_raw[0].due  == cyc) begin e = q_raw.pop_front();  cmp("raw",  e, r_d, r_c, r_s, r_e); end
    end

    // Write clean word a with data/check flips; record the decode-only expectation.
    task automatic inj(input int a, input logic [63:0] w, input logic [63:0] dm,
                       input logic [7:0] cm, input logic xs, input logic xe, input int req);
        logic [63:0] st;
        logic [7:0]  ex;
        st = w ^ dm;
        ex = ref_chk(w) ^ cm;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'(a); wr_data = st; wr_chk = ex;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 encoder check output", {66'd0, f_co}, {66'd0, ref_chk(st)});
        check("R2 check output zero without encoder", {66'd0, d_co}, 74'd0);
        m_store[a] = st; m_ext[a] = ex; m_ds[a] = xs; m_de[a] = xe; m_req[a] = req;
        m_dd[a] = xs ? w : st;
        m_dc[a] = xs ? ref_chk(w) : ex;
    endtask

    // Issue one read and queue expectations for every configuration (R3 due cycles).
    task automatic rd(input int a);
        exp_t e;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 9'(a);
        e.d = m_store[a]; e.c = ref_chk(m_store[a]); e.s = 1'b0; e.e = 1'b0;
        e.due = cyc + 1; e.req = 1;  q_full.push_back(e);   // R1
        e.req = 9;                   q_enc.push_back(e);    // R9
        e.c = m_ext[a]; e.due = cyc + 2; e.req = 10; q_raw.push_back(e); // R10
        e.d = m_dd[a]; e.c = m_dc[a]; e.s = m_ds[a]; e.e = m_de[a]; e.req = m_req[a];
        q_dec.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rd_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [73:0] hold_f, hold_d;
        repeat (3) @(negedge clk);
        // R11: everything zero under reset
        check("R11 full outputs", {f_d, f_c, f_s, f_e}, 74'd0);
        check("R11 dec outputs",  {d_d, d_c, d_s, d_e}, 74'd0);
        check("R11 check output", {66'd0, f_co}, 74'd0);
        rst_n = 1'b1;

        inj(0, 64'h0123_4567_89AB_CDEF, 64'd0, 8'h00, 1'b0, 1'b0, 1);      // R1 clean
        inj(1, 64'hFEDC_BA98_7654_3210, 64'd1 << 17, 8'h00, 1'b1, 1'b0, 5); // R5 data bit 17
        inj(2, 64'h5555_AAAA_3333_CCCC, 64'd1 << 63, 8'h00, 1'b1, 1'b0, 5); // R5 data bit 63
        inj(3, 64'h0F0F_F0F0_1234_8765, 64'd0, 8'h08, 1'b1, 1'b0, 4);      // R4 R6 check bit 3 stored from wr_chk
        inj(4, 64'hDEAD_BEEF_0000_FFFF, 64'd0, 8'h80, 1'b1, 1'b0, 6);      // R6 overall bit
        inj(5, 64'h1357_9BDF_2468_ACE0, (64'd1 << 5) | (64'd1 << 40), 8'h00, 1'b0, 1'b1, 7); // R7 two data
        inj(6, 64'hA5A5_5A5A_C3C3_3C3C, 64'd0, 8'h42, 1'b0, 1'b1, 7);      // R7 two check
        inj(7, 64'h7777_8888_9999_6666, 64'd1 << 9, 8'h04, 1'b0, 1'b1, 7); // R7 data + check
        inj(8, 64'd0, 64'd1, 8'h00, 1'b1, 1'b0, 5);                        // R5 data bit 0 of zero word
        inj(9, '1, 64'd0, 8'h00, 1'b0, 1'b0, 1);                           // R1 all ones

        for (int a = 0; a < 10; a++) rd(a);   // R3 back-to-back reads
        rd(9); rd(0); rd(5);
        idle(4);

        // R12: outputs hold while the last-read address is rewritten
        hold_f = {f_d, f_c, f_s, f_e};
        hold_d = {d_d, d_c, d_s, d_e};
        inj(5, 64'h0BAD_F00D_CAFE_0001, 64'd0, 8'h00, 1'b0, 1'b0, 1);
        repeat (3) @(negedge clk);
        check("R12 full hold", {f_d, f_c, f_s, f_e}, hold_f);
        check("R12 dec hold",  {d_d, d_c, d_s, d_e}, hold_d);

        rd(5); rd(1);
        idle(4);
        check("R3 scoreboard drained", {42'd0, 32'(q_full.size() + q_dec.size() + q_enc.size() + q_raw.size())}, 74'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule